// File: doc/BRIEF.md
# Data-Space Bank Switching Unit

This unit sits between an 8-bit processor data-space bus and four 64-byte memory pages. Two of the pages are EEPROM pages and two are RAM pages. All four are modelled here as plain internal arrays. A select register at data-space address CBh decides which page answers the low window, addresses 00h to 3Fh. Software writes a one-hot code into the register. Later window accesses then use address bits 5:0 as the offset into the chosen page, exactly as if that page were bank 0.

The select register is write-only. Reading its address always returns 00h. It has no reset value, so it keeps whatever it last held across a reset, and it must be written before the window is first used. Only full-byte writes change it.

When more than one select bit is set, the unit raises an error output. It also drives every page enable together, which makes the illegal state visible at the ports.

Top module: `bank_switch_unit`

## Requirements
- R1: A write with `addr_i` = CBh loads all eight bits of `wdata_i` into the select register on that clock edge. A read of CBh returns 00h.
- R2: Page enable mapping, with the select register holding exactly one used bit. Register bit 0 enables `page_en_o[0]` (EEPROM page 0). Bit 1 enables `page_en_o[1]` (EEPROM page 1). Bit 3 enables `page_en_o[2]` (RAM page 1). Bit 4 enables `page_en_o[3]` (RAM page 2). An enable is driven only while a read or write targets 00h–3Fh.
- R3: A window write commits `wdata_i` to offset `addr_i[5:0]` of each enabled page on the clock edge where `we_i` is high. A window read returns the addressed byte combinationally in the same cycle.
- R4: Each page has its own storage. A byte written through one page is not visible through another page at the same offset.
- R5: When none of register bits 0, 1, 3 and 4 is set, a window access enables no page, stores nothing, and reads 00h.
- R6: When two or more of bits 0, 1, 3 and 4 are set, `bank_err_o` is high. During a window access all four enables are high, a write stores into all four pages, and a read returns the bitwise OR of the four bytes at that offset.
- R7: An access to any address above 3Fh other than CBh enables no page, stores nothing, and reads 00h.
- R8: Reset does not change the select register. The page chosen before a reset pulse is still chosen after it.
- R9: Register bits 2, 5, 6 and 7 do not affect page selection or `bank_err_o`.
- R10: A new write to CBh replaces the previous selection entirely. The pages enabled before that write are no longer enabled.
- R11: `rdata_o` is 00h whenever `re_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset (does not clear the select register) |
| addr_i | input | 8 | Data-space address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Read data |
| page_en_o | output | 4 | Page enables: [0] EEPROM 0, [1] EEPROM 1, [2] RAM 1, [3] RAM 2 |
| bank_err_o | output | 1 | More than one select bit set |

## Verification
The assertions check several properties on every cycle:
- reads of CBh return zero;
- the register loads only on a write to CBh, and holds otherwise;
- at most one enable is active unless the error flag is up;
- all enables are active during a conflicting window access;
- out-of-window addresses stay quiet;
- an idle read port stays zero.

Some behaviours can only be shown by the bench's scenarios, run against a behavioural page model:
- that data lands in the right page and stays isolated from the others;
- that a conflicting write reaches all four pages;
- that the selection survives a reset pulse;
- that ignored writes leave page contents unchanged.

// File: rtl/bank_sw_pkg.sv
package bank_sw_pkg;
  localparam int unsigned DATA_W    = 8;
  localparam int unsigned ADDR_W    = 8;
  localparam int unsigned OFFS_W    = 6;
  localparam int unsigned NUM_PAGES = 4;
  localparam logic [ADDR_W-1:0] SEL_ADDR = 8'hCB;

  // page index -> select register bit (order is decoded by software)
  function automatic int unsigned sel_bit(input int unsigned idx);
    case (idx)
      0:       return 0;  // EEPROM page 0
      1:       return 1;  // EEPROM page 1
      2:       return 3;  // RAM page 1
      default: return 4;  // RAM page 2
    endcase
  endfunction
endpackage

// File: rtl/bank_sel_reg.sv
module bank_sel_reg
  import bank_sw_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = ADDR_W,
  parameter logic [AW-1:0] REG_ADDR = SEL_ADDR
) (
  input  logic          clk_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          we_i,
  output logic [DW-1:0] sel_o
);
  logic          load;
  logic [DW-1:0] sel_q;

  assign load = we_i && (addr_i == REG_ADDR);

  // deliberately no reset: contents survive rst_ni
  always_ff @(posedge clk_i) begin
    if (load) sel_q <= wdata_i;
  end

  assign sel_o = sel_q;
endmodule

// File: rtl/bank_decode.sv
module bank_decode
  import bank_sw_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned NP = NUM_PAGES
) (
  input  logic [DW-1:0] sel_i,
  output logic [NP-1:0] en_o,
  output logic          err_o
);
  logic [NP-1:0] used;
  int unsigned   cnt;

  for (genvar g = 0; g < NP; g++) begin : g_used
    assign used[g] = sel_i[sel_bit(g)];
  end

  always_comb begin
    cnt   = $countones(used);
    err_o = (cnt > 1);
    en_o  = err_o ? '1 : used;
  end
endmodule

// File: rtl/bank_page.sv
module bank_page #(
  parameter int unsigned DW = 8,
  parameter int unsigned OW = 6
) (
  input  logic          clk_i,
  input  logic          en_i,
  input  logic          we_i,
  input  logic [OW-1:0] offs_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << OW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (en_i && we_i) mem_q[offs_i] <= wdata_i;
  end

  assign rdata_o = en_i ? mem_q[offs_i] : '0;
endmodule

// File: rtl/bank_switch_unit.sv
module bank_switch_unit
  import bank_sw_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned OW = OFFS_W,
  parameter int unsigned NP = NUM_PAGES,
  parameter logic [AW-1:0] REG_ADDR = SEL_ADDR
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          we_i,
  input  logic          re_i,
  output logic [DW-1:0] rdata_o,
  output logic [NP-1:0] page_en_o,
  output logic          bank_err_o
);
  logic [DW-1:0] sel_q;
  logic [NP-1:0] dec_en;
  logic          win_hit;
  logic          win_acc;
  logic [DW-1:0] pg_rd [NP];
  logic [DW-1:0] or_rd;

  bank_sel_reg #(.DW(DW), .AW(AW), .REG_ADDR(REG_ADDR)) u_sel (
    .clk_i  (clk_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .we_i   (we_i),
    .sel_o  (sel_q)
  );

  bank_decode #(.DW(DW), .NP(NP)) u_dec (
    .sel_i(sel_q),
    .en_o (dec_en),
    .err_o(bank_err_o)
  );

  assign win_hit   = (addr_i[AW-1:OW] == '0);
  assign win_acc   = win_hit && (re_i || we_i);
  assign page_en_o = win_acc ? dec_en : '0;

  for (genvar p = 0; p < NP; p++) begin : g_page
    bank_page #(.DW(DW), .OW(OW)) u_page (
      .clk_i  (clk_i),
      .en_i   (page_en_o[p]),
      .we_i   (we_i),
      .offs_i (addr_i[OW-1:0]),
      .wdata_i(wdata_i),
      .rdata_o(pg_rd[p])
    );
  end

  always_comb begin
    or_rd = '0;
    for (int k = 0; k < NP; k++) or_rd |= pg_rd[k];
  end

  // CBh and all non-window addresses fall through to zero
  assign rdata_o = (re_i && win_hit) ? or_rd : '0;

  AST_SEL_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && addr_i == REG_ADDR) |-> rdata_o == '0);  // R1
  AST_SEL_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == REG_ADDR) |=> sel_q == $past(wdata_i));  // R10
  AST_SEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == REG_ADDR) |=> $stable(sel_q));  // R8
  AST_SINGLE_PAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bank_err_o |-> $onehot0(page_en_o));  // R2
  AST_CONFLICT_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank_err_o && addr_i[AW-1:OW] == '0 && (re_i || we_i)) |-> &page_en_o);  // R6
  AST_OUTSIDE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[AW-1:OW] != '0) |-> (page_en_o == '0 && rdata_o == '0));  // R7
  AST_IDLE_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |-> rdata_o == '0);  // R11
  AST_NO_PAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_q[0] && !sel_q[1] && !sel_q[3] && !sel_q[4]) |-> (page_en_o == '0 && rdata_o == '0));  // R5
endmodule

// File: tb/bank_switch_unit_test.sv
module bank_switch_unit_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] wdata = 8'h00;
  logic       we = 1'b0;
  logic       re = 1'b0;
  logic [7:0] rdata_o;
  logic [3:0] page_en_o;
  logic       bank_err_o;

  int checks = 0;
  int errors = 0;

  // behavioural reference
  byte unsigned mem [4][64];
  byte unsigned sel = 0;
  bit           sel_known = 0;

  always #2 clk = ~clk;  // 250 MHz

  bank_switch_unit uut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .re_i(re), .rdata_o(rdata_o), .page_en_o(page_en_o),
    .bank_err_o(bank_err_o)
  );

  function automatic int pop_used(input byte unsigned s);
    return int'(s[0]) + int'(s[1]) + int'(s[3]) + int'(s[4]);
  endfunction

  function automatic logic [3:0] model_en(input byte unsigned s);
    if (pop_used(s) > 1) return 4'hF;
    return {s[4], s[3], s[1], s[0]};
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input byte unsigned a, input byte unsigned d, input bit w, input bit r, input string tag);
    logic [3:0] e_en;
    byte unsigned e_rd;
    bit win;
    @(negedge clk);
    addr = a; wdata = d; we = w; re = r;
    #1;
    win  = (a < 64);
    e_en = (win && (w || r)) ? model_en(sel) : 4'h0;
    e_rd = 0;
    if (r && win)
      for (int k = 0; k < 4; k++) if (e_en[k]) e_rd |= mem[k][a];
    if (sel_known || !win) begin
      check(tag, "rdata", int'(rdata_o), int'(e_rd));
      check(tag, "page_en", int'(page_en_o), int'(e_en));
    end
    if (sel_known) check(tag, "err", int'(bank_err_o), (pop_used(sel) > 1) ? 1 : 0);
    @(posedge clk);
    if (w && a == 8'hCB) begin
      sel = d; sel_known = 1;
    end else if (w && win) begin
      for (int k = 0; k < 4; k++) if (e_en[k]) mem[k][a] = d;
    end
  endtask

  task automatic pulse_reset();
    @(negedge clk);
    we = 0; re = 0; rst_ni = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    byte unsigned codes [4];
    codes[0] = 8'h01; codes[1] = 8'h02; codes[2] = 8'h08; codes[3] = 8'h10;

    // reset state
    repeat (3) @(negedge clk);
    check("R11", "rdata in reset", int'(rdata_o), 0);
    rst_ni = 1;
    step(8'hCB, 8'h00, 0, 1, "R1");
    step(8'h80, 8'h00, 0, 1, "R7");

    // fill each page with a distinct pattern (R2, R3)
    for (int p = 0; p < 4; p++) begin
      step(8'hCB, codes[p], 1, 0, "R2");
      for (int a = 0; a < 64; a++) step(byte'(a), byte'((p * 64 + a) ^ 8'h5A), 1, 0, "R3");
    end

    // read back, page isolation
    for (int p = 0; p < 4; p++) begin
      step(8'hCB, codes[p], 1, 0, "R2");
      for (int a = 0; a < 64; a++) step(byte'(a), 8'h00, 0, 1, "R4");
    end

    // register reads as zero, write and read same cycle in window
    step(8'hCB, 8'h08, 1, 1, "R1");
    step(8'hCB, 8'h00, 0, 1, "R1");
    step(8'h11, 8'hC3, 1, 1, "R3");
    step(8'h11, 8'h00, 0, 1, "R3");

    // no page selected
    step(8'hCB, 8'h00, 1, 0, "R5");
    step(8'h05, 8'hEE, 1, 0, "R5");
    step(8'h05, 8'h00, 0, 1, "R5");
    foreach (codes[p]) begin
      step(8'hCB, codes[p], 1, 0, "R5");
      step(8'h05, 8'h00, 0, 1, "R5");
    end

    // unused bits
    step(8'hCB, 8'h04, 1, 0, "R9");
    step(8'h06, 8'h00, 0, 1, "R9");
    step(8'hCB, 8'hE4, 1, 0, "R9");
    step(8'h06, 8'h99, 1, 1, "R9");
    step(8'hCB, 8'h21, 1, 0, "R9");
    step(8'h06, 8'h00, 0, 1, "R9");
    step(8'hCB, 8'hF7, 1, 0, "R9");
    step(8'h06, 8'h00, 0, 1, "R9");

    // conflicting selections
    step(8'hCB, 8'h19, 1, 0, "R6");
    step(8'h07, 8'h00, 0, 1, "R6");
    step(8'hCB, 8'h03, 1, 0, "R6");
    step(8'h07, 8'hA5, 1, 0, "R6");
    step(8'h07, 8'h00, 0, 1, "R6");
    foreach (codes[p]) begin
      step(8'hCB, codes[p], 1, 0, "R6");
      step(8'h07, 8'h00, 0, 1, "R6");
    end

    // full-byte replacement
    step(8'hCB, 8'h08, 1, 0, "R10");
    step(8'hCB, 8'h10, 1, 0, "R10");
    step(8'h20, 8'h00, 0, 1, "R10");

    // survives reset
    step(8'hCB, 8'h02, 1, 0, "R8");
    pulse_reset();
    step(8'h21, 8'h00, 0, 1, "R8");
    step(8'h21, 8'h3C, 1, 1, "R8");
    step(8'h21, 8'h00, 0, 1, "R8");

    // outside addresses ignored
    step(8'h40, 8'hFF, 1, 1, "R7");
    step(8'h80, 8'hFF, 1, 1, "R7");
    step(8'hCA, 8'hFF, 1, 1, "R7");
    step(8'hFF, 8'hFF, 1, 1, "R7");
    step(8'h00, 8'h00, 0, 1, "R7");
    step(8'h3F, 8'h00, 0, 1, "R7");

    // idle read strobe
    step(8'h21, 8'h00, 0, 0, "R11");
    step(8'h21, 8'h77, 1, 0, "R11");

    // mixed traffic
    for (int i = 0; i < 600; i++) begin
      int c;
      byte unsigned a, d;
      c = $urandom % 10;
      d = byte'($urandom);
      if (c < 6) a = byte'($urandom % 64);
      else if (c == 6) begin
        a = 8'hCB;
        case ($urandom % 6)
          0: d = 8'h00; 1: d = 8'h01; 2: d = 8'h02; 3: d = 8'h08; 4: d = 8'h10; default: ;
        endcase
      end else begin
        a = byte'(64 + $urandom % 192);
        if (a == 8'hCB) a = 8'h40;
      end
      step(a, d, 1'($urandom), 1'($urandom), "R3");
    end

    @(negedge clk);
    we = 0; re = 0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule